// File: doc/BRIEF.md
# Linked Descriptor DMA Channel

This block is one DMA channel that works through a chain of four-word descriptors. Each descriptor holds a control word, a source address, a destination address and a link word. The channel moves the number of data units named in the control word from source to destination over a simple memory request/acknowledge port. Each unit is moved as one read followed by one write. When a descriptor is finished, the channel either stops or fetches the next descriptor from the address in its link word.

Software can start the channel in two ways. It can write the four descriptor registers and pulse `start_i`. It can also write only the link register and pulse `link_load_i`, which makes the channel fetch its first descriptor from memory. Addresses taken from a fetched descriptor can be absolute, or they can be relative offsets added to the live register contents. A descriptor fetched by a link load is always read as absolute.

Top module: `desc_dma_channel`

## Requirements
- R1: After reset the channel is idle: `busy_o`, `done_o` and `mem_req_o` are low, and `ctrl_o`, `src_o`, `dst_o` and `link_o` are zero.
- R2: While the channel is idle, writes through `reg_we_i` update the register chosen by `reg_sel_i` (0 control, 1 source, 2 destination, 3 link). A `start_i` pulse with `en_i` high then runs the descriptor held in the registers. For each unit the channel reads at the source address, then writes the read data, zero-extended, to the destination address. The number of units is control bits [15:0].
- R3: Control bits [17:16] select the unit size: 00 is 1 byte, 01 is 2 bytes, 10 is 4 bytes. `mem_size_o` carries this code. After each unit is written, the source and destination registers both advance by the unit size, so on completion each points one unit past the last one moved.
- R4: A descriptor with a count of zero completes without any memory access.
- R5: When a descriptor finishes with link bit 0 clear, `done_o` goes high for exactly one cycle, and `busy_o` is low during that cycle.
- R6: A `link_load_i` pulse with `en_i` high fetches four words, as 4-byte reads in the order control, source, destination, link. They are read at offsets +0, +4, +8 and +12 from the link register with its two low bits forced to zero. This first descriptor treats all of its addresses as absolute, whatever its mode bits say.
- R7: When a descriptor finishes with link bit 0 set, the channel fetches the next descriptor from the link address. Afterwards `ctrl_o`, `src_o`, `dst_o` and `link_o` hold the fetched contents, with addresses resolved.
- R8: In a linked descriptor, control bit 18 makes the source field relative and bit 19 makes the destination field relative. A relative field is added to the current register contents, so an offset of zero continues sequentially.
- R9: Bit 1 of a link word makes its address relative. The new link address is then the current link address (low bits cleared) plus the word with its low bits cleared. `link_o` keeps the two flag bits of the fetched word.
- R10: Lowering `en_i` while busy stops the channel. No further memory requests are made and no done pulse occurs. `src_o` and `dst_o` keep the address of the next unit that would have been moved.
- R11: A memory request that is not acknowledged stays asserted, with the same address and direction, for as long as `en_i` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Channel enable level |
| start_i | input | 1 | Start from the register contents |
| link_load_i | input | 1 | Start by fetching a descriptor at the link address |
| reg_we_i | input | 1 | Register write strobe (idle only) |
| reg_sel_i | input | 2 | Register select: 0 ctrl, 1 src, 2 dst, 3 link |
| reg_wdata_i | input | 32 | Register write data |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_size_o | output | 2 | Access size code |
| mem_addr_o | output | 32 | Byte address |
| mem_wdata_o | output | 32 | Write data, right-justified |
| mem_ack_i | input | 1 | Request accepted; read data valid in the same cycle |
| mem_rdata_i | input | 32 | Read data, right-justified from the address |
| busy_o | output | 1 | Channel active |
| done_o | output | 1 | One-cycle completion pulse |
| ctrl_o | output | 32 | Control register |
| src_o | output | 32 | Source address register |
| dst_o | output | 32 | Destination address register |
| link_o | output | 32 | Link register with flags |

## Verification
A behavioural model works out, ahead of time, every memory access a run should make, and each acknowledged access is compared against it. The memory stalls acknowledges on a fixed pattern, so a request that dropped or changed while waiting would be caught. The chain test gives the first descriptor relative mode bits, which must be ignored, and a link word with nonzero flag bits. A design that honoured those bits would fetch from the wrong address. Later descriptors then use a relative source with offset zero, a relative destination with a nonzero offset and a relative link step of 16 bytes. An adder on the wrong base would show up as wrong addresses. The other tests cover byte, half-word and zero-count runs, which catch a wrong step size or a spurious access. The last test drops the enable in the middle of a run: a design that went on, pulsed done, or rolled its pointers back would fail it.

// File: rtl/desc_dma_pkg.sv
package desc_dma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_RD,
    ST_WR,
    ST_END
  } dma_state_e;

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;
  localparam logic [1:0] SZ_WORD = 2'b10;

  function automatic logic [2:0] unit_bytes(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: unit_bytes = 3'd1;
      SZ_HALF: unit_bytes = 3'd2;
      default: unit_bytes = 3'd4;
    endcase
  endfunction

  function automatic logic [31:0] mask_unit(input logic [31:0] d, input logic [1:0] sz);
    case (sz)
      SZ_BYTE: mask_unit = {24'd0, d[7:0]};
      SZ_HALF: mask_unit = {16'd0, d[15:0]};
      default: mask_unit = d;
    endcase
  endfunction

endpackage

// File: rtl/dma_addr_resolve.sv
module dma_addr_resolve #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] field_i,
  input  logic          rel_i,
  input  logic          first_i,
  output logic [AW-1:0] addr_o
);
  // first descriptor after a link load is always absolute
  assign addr_o = (rel_i && !first_i) ? base_i + field_i : field_i;
endmodule

// File: rtl/dma_unit_cnt.sv
module dma_unit_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             last_o
);
  logic [CNT_W-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rem_q <= '0;
    else if (load_i)  rem_q <= load_val_i;
    else if (dec_i)   rem_q <= rem_q - 1'b1;
  end

  assign last_o = (rem_q == CNT_W'(1));

  assert_no_underflow_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !load_i) |-> (rem_q != '0));
endmodule

// File: rtl/desc_dma_channel.sv
module desc_dma_channel
  import desc_dma_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CNT_W = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          start_i,
  input  logic          link_load_i,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_sel_i,
  input  logic [AW-1:0] reg_wdata_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [1:0]    mem_size_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [AW-1:0] mem_wdata_o,
  input  logic          mem_ack_i,
  input  logic [AW-1:0] mem_rdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [AW-1:0] ctrl_o,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic [AW-1:0] link_o
);
  localparam int SZ_LSB      = CNT_W;
  localparam int SRC_REL_BIT = CNT_W + 2;
  localparam int DST_REL_BIT = CNT_W + 3;

  dma_state_e  state_q;
  logic [AW-1:0] ctrl_q, src_q, dst_q, link_q, data_q;
  logic [1:0]    wcnt_q;
  logic          first_q, done_q;

  logic          hs, cnt_zero, cnt_last, cnt_load, cnt_dec;
  logic [1:0]    size_w;
  logic [AW-1:0] unit_ext, link_base, fetch_addr;
  logic [AW-1:0] src_res, dst_res, lnk_res;

  assign size_w     = ctrl_q[SZ_LSB+1:SZ_LSB];
  assign unit_ext   = AW'(unit_bytes(size_w));
  assign link_base  = {link_q[AW-1:2], 2'b00};
  assign fetch_addr = link_base + AW'({wcnt_q, 2'b00});
  assign cnt_zero   = (ctrl_q[CNT_W-1:0] == '0);

  assign mem_req_o   = en_i && (state_q inside {ST_FETCH, ST_RD, ST_WR});
  assign mem_we_o    = (state_q == ST_WR);
  assign mem_size_o  = (state_q == ST_FETCH) ? SZ_WORD : size_w;
  assign mem_wdata_o = data_q;
  always_comb begin
    case (state_q)
      ST_FETCH: mem_addr_o = fetch_addr;
      ST_WR:    mem_addr_o = dst_q;
      default:  mem_addr_o = src_q;
    endcase
  end
  assign hs = mem_req_o && mem_ack_i;

  dma_addr_resolve #(.AW(AW)) i_src_res (
    .base_i(src_q), .field_i(mem_rdata_i), .rel_i(ctrl_q[SRC_REL_BIT]),
    .first_i(first_q), .addr_o(src_res));
  dma_addr_resolve #(.AW(AW)) i_dst_res (
    .base_i(dst_q), .field_i(mem_rdata_i), .rel_i(ctrl_q[DST_REL_BIT]),
    .first_i(first_q), .addr_o(dst_res));
  dma_addr_resolve #(.AW(AW)) i_lnk_res (
    .base_i(link_base), .field_i({mem_rdata_i[AW-1:2], 2'b00}), .rel_i(mem_rdata_i[1]),
    .first_i(first_q), .addr_o(lnk_res));

  assign cnt_load = (state_q == ST_IDLE && en_i && !link_load_i && start_i) ||
                    (state_q == ST_FETCH && hs && wcnt_q == 2'd3);
  assign cnt_dec  = (state_q == ST_WR) && hs;

  dma_unit_cnt #(.CNT_W(CNT_W)) i_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(cnt_load),
    .load_val_i(ctrl_q[CNT_W-1:0]), .dec_i(cnt_dec), .last_o(cnt_last));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ctrl_q  <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      link_q  <= '0;
      data_q  <= '0;
      wcnt_q  <= '0;
      first_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (state_q != ST_IDLE && !en_i) begin
        state_q <= ST_IDLE;  // abort keeps pointers at next unit
      end else begin
        case (state_q)
          ST_IDLE: begin
            if (reg_we_i) begin
              case (reg_sel_i)
                2'd0:    ctrl_q <= reg_wdata_i;
                2'd1:    src_q  <= reg_wdata_i;
                2'd2:    dst_q  <= reg_wdata_i;
                default: link_q <= reg_wdata_i;
              endcase
            end
            if (en_i && link_load_i) begin
              first_q <= 1'b1;
              wcnt_q  <= '0;
              state_q <= ST_FETCH;
            end else if (en_i && start_i) begin
              first_q <= 1'b0;
              state_q <= cnt_zero ? ST_END : ST_RD;
            end
          end
          ST_FETCH: if (hs) begin
            wcnt_q <= wcnt_q + 2'd1;
            case (wcnt_q)
              2'd0: ctrl_q <= mem_rdata_i;
              2'd1: src_q  <= src_res;
              2'd2: dst_q  <= dst_res;
              default: begin
                link_q  <= {lnk_res[AW-1:2], mem_rdata_i[1:0]};
                first_q <= 1'b0;
                state_q <= cnt_zero ? ST_END : ST_RD;
              end
            endcase
          end
          ST_RD: if (hs) begin
            data_q  <= mask_unit(mem_rdata_i, size_w);
            state_q <= ST_WR;
          end
          ST_WR: if (hs) begin
            src_q   <= src_q + unit_ext;
            dst_q   <= dst_q + unit_ext;
            state_q <= cnt_last ? ST_END : ST_RD;
          end
          ST_END: begin
            if (link_q[0]) begin
              wcnt_q  <= '0;
              state_q <= ST_FETCH;
            end else begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
  assign ctrl_o = ctrl_q;
  assign src_o  = src_q;
  assign dst_o  = dst_q;
  assign link_o = link_q;

  assert_req_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i && en_i) |=>
      (!en_i || (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o))));

  assert_ptr_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && mem_ack_i) |=>
      (src_o == $past(src_o) + $past(unit_ext)) && (dst_o == $past(dst_o) + $past(unit_ext)));

  assert_done_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_done_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_fetch_align_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && state_q == ST_FETCH) |-> (mem_addr_o[1:0] == 2'b00 && !mem_we_o));

  assert_abort_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !en_i) |=> (!busy_o && !done_o));
endmodule

// File: tb/test_desc_dma_channel.sv
module test_desc_dma_channel;
  timeunit 1ns; timeprecision 100ps;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, en, start, link_load, reg_we;
  logic [1:0] reg_sel;
  logic [31:0] reg_wdata;
  logic mem_req, mem_we, mem_ack;
  logic [1:0] mem_size;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic busy, done;
  logic [31:0] ctrl_v, src_v, dst_v, link_v;

  desc_dma_channel i_desc_dma_channel (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .start_i(start), .link_load_i(link_load),
    .reg_we_i(reg_we), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_size_o(mem_size), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata),
    .busy_o(busy), .done_o(done), .ctrl_o(ctrl_v), .src_o(src_v), .dst_o(dst_v), .link_o(link_v));

  int n_chk = 0, n_err = 0;
  int n_wr = 0, n_done = 0, n_hs = 0, ack_ctr = 0;
  bit fin = 0, prev_stall = 0, prev_done = 0;
  logic [31:0] prev_addr;

  logic [7:0] mem [logic [31:0]];
  logic        q_we   [$];
  logic [31:0] q_addr [$];
  logic [1:0]  q_sz   [$];
  logic [31:0] q_dat  [$];

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  function automatic logic [7:0] rd8(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction
  function automatic logic [31:0] rd32(input logic [31:0] a);
    return {rd8(a + 3), rd8(a + 2), rd8(a + 1), rd8(a)};
  endfunction
  function automatic logic [31:0] rd_unit(input logic [31:0] a, input int u);
    if (u == 1) return {24'd0, rd8(a)};
    if (u == 2) return {16'd0, rd8(a + 1), rd8(a)};
    return rd32(a);
  endfunction
  function automatic void wr32(input logic [31:0] a, input logic [31:0] d);
    for (int k = 0; k < 4; k++) mem[a + k] = d[8*k +: 8];
  endfunction

  // memory model and handshake monitor, away from the active edge
  always @(negedge clk) begin
    #1;
    ack_ctr++;
    mem_ack   = (ack_ctr % 3) != 1;
    mem_rdata = rd32(mem_addr);
    if (rst_n) begin
      if (prev_stall && en) begin
        chk("R11 request held", {31'd0, mem_req}, 32'd1);
        chk("R11 address held", mem_addr, prev_addr);
      end
      prev_stall = mem_req && !mem_ack;
      prev_addr  = mem_addr;
      if (mem_req && mem_ack) begin
        n_hs++;
        if (q_we.size() == 0) begin
          chk("R2 unexpected access", mem_addr, 32'hFFFF_FFFF);
        end else begin
          logic ewe; logic [31:0] ea, ed; logic [1:0] es;
          ewe = q_we.pop_front(); ea = q_addr.pop_front();
          es = q_sz.pop_front(); ed = q_dat.pop_front();
          chk("R2 direction", {31'd0, mem_we}, {31'd0, ewe});
          chk("R6 R8 R9 address", mem_addr, ea);
          chk("R3 size code", {30'd0, mem_size}, {30'd0, es});
          if (mem_we) chk("R2 write data", mem_wdata, ed);
        end
        if (mem_we) begin
          for (int k = 0; k < (mem_size == 2'b00 ? 1 : mem_size == 2'b01 ? 2 : 4); k++)
            mem[mem_addr + k] = mem_wdata[8*k +: 8];
          n_wr++;
        end
      end
      if (done) begin
        n_done++;
        if (prev_done) chk("R5 done width", 32'd2, 32'd1);
        chk("R5 idle at done", {31'd0, busy}, 32'd0);
      end
      prev_done = done;
    end
  end

  task automatic push(input logic we, input logic [31:0] a, input logic [1:0] sz, input logic [31:0] d);
    q_we.push_back(we); q_addr.push_back(a); q_sz.push_back(sz); q_dat.push_back(d);
  endtask

  // behavioural expectation of one run
  task automatic build_exp(input bit via_link, input logic [31:0] c0, s0, d0, l0,
                           output logic [31:0] ec, es, ed, el);
    logic [31:0] c, s, d, l, base, w1, w2, w3, nl;
    bit first, fetch;
    int u;
    c = c0; s = s0; d = d0; l = l0; first = via_link; fetch = via_link;
    for (int guard = 0; guard < 16; guard++) begin
      if (fetch) begin
        base = {l[31:2], 2'b00};
        for (int k = 0; k < 4; k++) push(1'b0, base + 32'(4 * k), 2'b10, 32'd0);
        c = rd32(base); w1 = rd32(base + 4); w2 = rd32(base + 8); w3 = rd32(base + 12);
        s  = (first || !c[18]) ? w1 : s + w1;
        d  = (first || !c[19]) ? w2 : d + w2;
        nl = (first || !w3[1]) ? {w3[31:2], 2'b00} : base + {w3[31:2], 2'b00};
        l  = {nl[31:2], w3[1:0]};
        first = 0;
      end
      u = (c[17:16] == 2'b00) ? 1 : (c[17:16] == 2'b01) ? 2 : 4;
      for (int i = 0; i < int'(c[15:0]); i++) begin
        push(1'b0, s, c[17:16], 32'd0);
        push(1'b1, d, c[17:16], rd_unit(s, u));
        s += 32'(u); d += 32'(u);
      end
      if (!l[0]) break;
      fetch = 1;
    end
    ec = c; es = s; ed = d; el = l;
  endtask

  task automatic reg_wr(input logic [1:0] sel, input logic [31:0] v);
    @(negedge clk); reg_we = 1; reg_sel = sel; reg_wdata = v;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic pulse(input bit use_link);
    @(negedge clk); en = 1;
    if (use_link) link_load = 1; else start = 1;
    @(negedge clk); link_load = 0; start = 0;
  endtask

  task automatic finish_run(input string tag, input logic [31:0] ec, es, ed, el);
    int t;
    t = 0;
    while (n_done == 0 && t < 3000) begin @(negedge clk); t++; end
    repeat (4) @(negedge clk);
    chk({tag, " done count"}, 32'(n_done), 32'd1);
    chk({tag, " busy low"}, {31'd0, busy}, 32'd0);
    chk({tag, " accesses left"}, 32'(q_we.size()), 32'd0);
    chk({tag, " R3 src end"}, src_v, es);
    chk({tag, " R3 dst end"}, dst_v, ed);
    chk({tag, " R7 ctrl reg"}, ctrl_v, ec);
    chk({tag, " R9 link reg"}, link_v, el);
  endtask

  task automatic direct_run(input string tag, input logic [31:0] c, s, d);
    logic [31:0] ec, es, ed, el;
    reg_wr(2'd0, c); reg_wr(2'd1, s); reg_wr(2'd2, d); reg_wr(2'd3, 32'd0);
    build_exp(1'b0, c, s, d, 32'd0, ec, es, ed, el);
    n_done = 0;
    pulse(1'b0);
    finish_run(tag, ec, es, ed, el);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!fin) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] ec, es, ed, el;
    int hs0, wr0;
    rst_n = 0; en = 0; start = 0; link_load = 0; reg_we = 0; reg_sel = 0; reg_wdata = 0;
    mem_ack = 0; mem_rdata = 0;
    for (int i = 0; i < 512; i++) mem[32'h1000 + i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    // R1
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 req", {31'd0, mem_req}, 32'd0);
    chk("R1 done", {31'd0, done}, 32'd0);
    chk("R1 src", src_v, 32'd0);
    chk("R1 link", link_v, 32'd0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R2 R3 word, byte, half
    direct_run("R2 word", 32'h0002_0003, 32'h0000_1000, 32'h0000_2000);
    direct_run("R3 byte", 32'h0000_0005, 32'h0000_1001, 32'h0000_2101);
    direct_run("R3 half", 32'h0001_0004, 32'h0000_1010, 32'h0000_2200);
    // R4 zero count: no access allowed
    hs0 = n_hs;
    direct_run("R4 zero", 32'h0002_0000, 32'h0000_1040, 32'h0000_2300);
    chk("R4 no access", 32'(n_hs - hs0), 32'd0);

    // R6 R7 R8 R9 chain of three descriptors
    wr32(32'h300, 32'h000E_0002); wr32(32'h304, 32'h0000_1000);
    wr32(32'h308, 32'h0000_2400); wr32(32'h30C, 32'h0000_0313);
    wr32(32'h310, 32'h0004_0003); wr32(32'h314, 32'h0000_0000);
    wr32(32'h318, 32'h0000_2500); wr32(32'h31C, 32'h0000_0013);
    wr32(32'h320, 32'h0009_0002); wr32(32'h324, 32'h0000_1100);
    wr32(32'h328, 32'h0000_0020); wr32(32'h32C, 32'h0000_0000);
    reg_wr(2'd3, 32'h0000_0302);
    build_exp(1'b1, ctrl_v, src_v, dst_v, 32'h0000_0302, ec, es, ed, el);
    chk("R8 model dst", ed, 32'h0000_2527);
    n_done = 0;
    pulse(1'b1);
    finish_run("R7 chain", ec, es, ed, el);

    // R10 abort mid-transfer
    reg_wr(2'd0, 32'h0002_0008); reg_wr(2'd1, 32'h0000_1000);
    reg_wr(2'd2, 32'h0000_2600); reg_wr(2'd3, 32'd0);
    build_exp(1'b0, 32'h0002_0008, 32'h0000_1000, 32'h0000_2600, 32'd0, ec, es, ed, el);
    n_done = 0; wr0 = n_wr;
    pulse(1'b0);
    while (n_wr - wr0 < 3) @(negedge clk);
    en = 0;
    @(negedge clk);
    hs0 = n_hs;
    repeat (10) @(negedge clk);
    chk("R10 no requests", 32'(n_hs - hs0), 32'd0);
    chk("R10 busy", {31'd0, busy}, 32'd0);
    chk("R10 no done", 32'(n_done), 32'd0);
    chk("R10 src next", src_v, 32'h0000_1000 + 32'(4 * (n_wr - wr0)));
    chk("R10 dst next", dst_v, 32'h0000_2600 + 32'(4 * (n_wr - wr0)));
    q_we.delete(); q_addr.delete(); q_sz.delete(); q_dat.delete();

    fin = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule